// File: doc/BRIEF.md
# Secured Configuration Store

This block keeps the configuration image of a programmable logic array: a set of connection rows, one of which carries the mode bits, a 64-bit signature word of free user data, and a lock flag. A synchronous command port lets a programmer write rows, write the signature, set the lock, wipe everything and read either the rows or the signature back. Each command is one cycle long and is answered one cycle later by a `done_o` pulse.

Once the lock is set, the row contents can no longer be read or changed. Row reads return zeros and row writes are dropped, and both raise `denied_o`. The signature stays readable and writable. The lock cannot be cleared by any command except a wipe, and a wipe also clears every row and the signature. Writing a row replaces its whole content, so no erase step is needed before programming.

Rows are held in a memory that can be mapped to block RAM. A vector of per-row "written" tags lets a wipe take effect in a single cycle. The mode bits are the low `MODE_W` bits of the highest row address; the store treats that row like any other.

Top module: `cfg_vault`

## Requirements
- R1: After reset, `done_o`, `denied_o`, `row_o` and `sig_o` are 0, the store is unlocked and every row reads as 0.
- R2: A cycle with `cmd_valid` high gives `done_o` high in the next cycle for exactly one cycle. A cycle with `cmd_valid` low gives `done_o` low in the next cycle.
- R3: Command code 1 (write row) stores `cmd_row` at `cmd_addr`, replacing all previous bits. A later code 5 (read row) of that address returns exactly that value on `row_o`, valid together with `done_o`. This holds for addresses 0 and 2**ADDR_W-1.
- R4: A row never written since reset or since the last wipe reads as 0.
- R5: While locked, code 5 returns 0 on `row_o` and raises `denied_o` for exactly one cycle, together with `done_o`.
- R6: While locked, code 1 does not change the stored row and raises `denied_o` together with `done_o`.
- R7: Code 2 stores `cmd_sig`, and code 6 places the stored signature on `sig_o`. Both work whether or not the store is locked, and neither raises `denied_o`.
- R8: Code 3 sets the lock. Only a wipe clears it: repeated locks, reads, writes and the unused codes 0 and 7 leave it set.
- R9: Code 4 (wipe) clears the lock, the signature and every row in one command. After a wipe, rows read 0 without denial and row writes take effect again.
- R10: `row_o` changes only on a row read, and `sig_o` changes only on a signature read. Between reads both hold their value.
- R11: `denied_o` is high only in the cycle after a row read or row write issued while locked. It is low for every other command and for idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset to the unprogrammed state |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 3 | Command code (1 write row, 2 write signature, 3 lock, 4 wipe, 5 read row, 6 read signature) |
| cmd_addr | input | ADDR_W | Row address for row commands |
| cmd_row | input | DATA_W | Row data for a row write |
| cmd_sig | input | SIG_W | Signature data for a signature write |
| done_o | output | 1 | One-cycle acknowledge of a command |
| denied_o | output | 1 | One-cycle flag: a row access was refused because of the lock |
| row_o | output | DATA_W | Result of the last row read |
| sig_o | output | SIG_W | Result of the last signature read |

## Verification
Every result is due exactly one clock edge after the command that causes it. The edge that captures the command also updates `done_o`, `denied_o`, `row_o` and `sig_o`. The bench drives each command on a falling edge, drops the strobe on the next falling edge and samples all outputs at that moment. This places the sample half a period after the edge that produced the result and before any later command. The bench also samples one idle cycle after a denied read, which confirms that `denied_o` lasts one cycle, and it takes samples across idle commands to confirm that the read outputs hold.

// File: rtl/cfg_vault_pkg.sv
package cfg_vault_pkg;

  typedef enum logic [2:0] {
    OP_IDLE   = 3'd0,
    OP_WR_ROW = 3'd1,
    OP_WR_SIG = 3'd2,
    OP_LOCK   = 3'd3,
    OP_WIPE   = 3'd4,
    OP_RD_ROW = 3'd5,
    OP_RD_SIG = 3'd6,
    OP_SPARE  = 3'd7
  } vault_op_e;

  typedef struct packed {
    logic wr_row;
    logic wr_sig;
    logic lock;
    logic wipe;
    logic rd_row;
    logic rd_sig;
    logic deny;
  } vault_strobe_t;

endpackage

// File: rtl/cfg_cmd_decode.sv
module cfg_cmd_decode
  import cfg_vault_pkg::*;
(
  input  logic          valid,
  input  logic [2:0]    op,
  input  logic          locked,
  output vault_strobe_t stb
);

  vault_op_e opc;
  logic      row_op;

  always_comb begin
    opc        = vault_op_e'(op);
    row_op     = (opc == OP_WR_ROW) || (opc == OP_RD_ROW);
    stb.wr_row = valid && (opc == OP_WR_ROW) && !locked;
    stb.wr_sig = valid && (opc == OP_WR_SIG);
    stb.lock   = valid && (opc == OP_LOCK);
    stb.wipe   = valid && (opc == OP_WIPE);
    stb.rd_row = valid && (opc == OP_RD_ROW);
    stb.rd_sig = valid && (opc == OP_RD_SIG);
    stb.deny   = valid && row_op && locked;
  end

endmodule

// File: rtl/cfg_row_mem.sv
module cfg_row_mem #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 40
) (
  input  logic              clk,
  input  logic              we,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata <= mem[addr];
  end

endmodule

// File: rtl/cfg_row_tags.sv
module cfg_row_tags #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set,
  input  logic              clear_all,
  input  logic              query,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DEPTH-1:0] tag;

  for (genvar i = 0; i < DEPTH; i++) begin : g_tag
    always_ff @(posedge clk) begin
      if (rst || clear_all)                      tag[i] <= 1'b0;
      else if (set && (addr == ADDR_W'(i)))      tag[i] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        hit <= 1'b0;
    else if (query) hit <= tag[addr];
  end

endmodule

// File: rtl/cfg_vault.sv
module cfg_vault
  import cfg_vault_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 40,
  parameter int SIG_W  = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_row,
  input  logic [SIG_W-1:0]  cmd_sig,
  output logic              done_o,
  output logic              denied_o,
  output logic [DATA_W-1:0] row_o,
  output logic [SIG_W-1:0]  sig_o
);

  vault_strobe_t     stb;
  logic              locked_q;
  logic [SIG_W-1:0]  sig_q;
  logic [DATA_W-1:0] mem_rd;
  logic              tag_hit;
  logic              allow_q;
  logic              row_we;

  cfg_cmd_decode u_dec (
    .valid  (cmd_valid),
    .op     (cmd_op),
    .locked (locked_q),
    .stb    (stb)
  );

  assign row_we = stb.wr_row;

  cfg_row_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk   (clk),
    .we    (row_we),
    .re    (stb.rd_row),
    .addr  (cmd_addr),
    .wdata (cmd_row),
    .rdata (mem_rd)
  );

  cfg_row_tags #(.ADDR_W(ADDR_W)) u_tags (
    .clk       (clk),
    .rst       (rst),
    .set       (row_we),
    .clear_all (stb.wipe),
    .query     (stb.rd_row),
    .addr      (cmd_addr),
    .hit       (tag_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      locked_q <= 1'b0;
      sig_q    <= '0;
      sig_o    <= '0;
      allow_q  <= 1'b0;
      done_o   <= 1'b0;
      denied_o <= 1'b0;
    end else begin
      done_o   <= cmd_valid;
      denied_o <= stb.deny;
      if (stb.wipe)        locked_q <= 1'b0;
      else if (stb.lock)   locked_q <= 1'b1;
      if (stb.wipe)        sig_q <= '0;
      else if (stb.wr_sig) sig_q <= cmd_sig;
      if (stb.rd_sig)      sig_o <= sig_q;
      if (stb.rd_row)      allow_q <= !locked_q;
    end
  end

  assign row_o = (tag_hit && allow_q) ? mem_rd : '0;

endmodule

// File: rtl/cfg_vault_chk.sv
module cfg_vault_chk
  import cfg_vault_pkg::*;
#(
  parameter int DATA_W = 40,
  parameter int SIG_W  = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_valid,
  input logic [2:0]        cmd_op,
  input logic              done_o,
  input logic              denied_o,
  input logic [DATA_W-1:0] row_o,
  input logic [SIG_W-1:0]  sig_o,
  input logic              locked_q,
  input logic              row_we
);

  p_done_follows_r2: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> done_o);

  p_done_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |=> !done_o);

  p_denied_with_done_r11: assert property (@(posedge clk) disable iff (rst)
    denied_o |-> done_o);

  p_denied_row_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == OP_RD_ROW && locked_q) |=> (denied_o && row_o == '0));

  p_no_write_locked_r6: assert property (@(posedge clk) disable iff (rst)
    row_we |-> !locked_q);

  p_lock_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (locked_q && !(cmd_valid && cmd_op == OP_WIPE)) |=> locked_q);

  p_wipe_unlocks_r9: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == OP_WIPE) |=> !locked_q);

  p_row_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !(cmd_valid && cmd_op == OP_RD_ROW) |=> $stable(row_o));

  p_sig_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !(cmd_valid && cmd_op == OP_RD_SIG) |=> $stable(sig_o));

endmodule

bind cfg_vault cfg_vault_chk #(.DATA_W(DATA_W), .SIG_W(SIG_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cmd_valid (cmd_valid),
  .cmd_op    (cmd_op),
  .done_o    (done_o),
  .denied_o  (denied_o),
  .row_o     (row_o),
  .sig_o     (sig_o),
  .locked_q  (locked_q),
  .row_we    (row_we)
);

// File: tb/cfg_vault_test.sv
`timescale 1ns/1ps
module cfg_vault_test;

  localparam int ADDR_W = 6;
  localparam int DATA_W = 40;
  localparam int SIG_W  = 64;
  localparam logic [ADDR_W-1:0] TOP = '1;

  logic              clk = 1'b0;
  logic              rst;
  logic              cmd_valid;
  logic [2:0]        cmd_op;
  logic [ADDR_W-1:0] cmd_addr;
  logic [DATA_W-1:0] cmd_row;
  logic [SIG_W-1:0]  cmd_sig;
  logic              done_o, denied_o;
  logic [DATA_W-1:0] row_o;
  logic [SIG_W-1:0]  sig_o;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  cfg_vault #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SIG_W(SIG_W)) uut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_row(cmd_row), .cmd_sig(cmd_sig),
    .done_o(done_o), .denied_o(denied_o), .row_o(row_o), .sig_o(sig_o)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one command: drive on a falling edge, sample at the next falling edge
  task automatic issue(input logic [2:0] op, input logic [ADDR_W-1:0] a,
                       input logic [DATA_W-1:0] r, input logic [SIG_W-1:0] s);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_row = r; cmd_sig = s;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 3'd0;
  endtask

  task automatic idle();
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic read_row(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] exp,
                          input logic exp_deny, input string req);
    issue(3'd5, a, '0, '0);
    check(row_o == exp, req, 64'(row_o), 64'(exp));
    check(denied_o == exp_deny && done_o, req, {62'd0, done_o, denied_o}, {62'd0, 1'b1, exp_deny});
  endtask

  task automatic read_sig(input logic [SIG_W-1:0] exp, input string req);
    issue(3'd6, '0, '0, '0);
    check(sig_o == exp && !denied_o, req, sig_o, exp);
  endtask

  task automatic t_reset();
    check(!done_o && !denied_o, "R1", {62'd0, done_o, denied_o}, 64'd0);
    check(row_o == '0 && sig_o == '0, "R1", 64'(row_o) | sig_o, 64'd0);
    read_row(6'd5, '0, 1'b0, "R1");
  endtask

  task automatic t_write_read();
    issue(3'd1, 6'd0, 40'h12_3456_789A, '0);
    check(done_o && !denied_o, "R2", {62'd0, done_o, denied_o}, 64'd2);
    read_row(6'd0, 40'h12_3456_789A, 1'b0, "R3");
    issue(3'd1, TOP, '1, '0);
    read_row(TOP, '1, 1'b0, "R3");
    issue(3'd1, 6'd0, 40'h00_0000_0F0F, '0);
    read_row(6'd0, 40'h00_0000_0F0F, 1'b0, "R3");
  endtask

  task automatic t_unwritten();
    read_row(6'd7, '0, 1'b0, "R4");
    read_row(6'd62, '0, 1'b0, "R4");
  endtask

  task automatic t_sig();
    issue(3'd2, '0, '0, 64'hDEAD_BEEF_0123_4567);
    check(!denied_o, "R7", 64'(denied_o), 64'd0);
    read_sig(64'hDEAD_BEEF_0123_4567, "R7");
  endtask

  task automatic t_hold();
    logic [DATA_W-1:0] r0;
    logic [SIG_W-1:0]  s0;
    r0 = row_o; s0 = sig_o;
    issue(3'd1, 6'd1, 40'hAA_AAAA_AAAA, '0);
    issue(3'd2, '0, '0, 64'h1111_2222_3333_4444);
    issue(3'd0, '0, '0, '0);
    idle();
    check(!done_o, "R2", 64'(done_o), 64'd0);
    check(row_o == r0, "R10", 64'(row_o), 64'(r0));
    check(sig_o == s0, "R10", sig_o, s0);
    read_row(6'd1, 40'hAA_AAAA_AAAA, 1'b0, "R3");
    read_sig(64'h1111_2222_3333_4444, "R7");
  endtask

  task automatic t_locked();
    issue(3'd3, '0, '0, '0);
    check(done_o && !denied_o, "R11", 64'(denied_o), 64'd0);
    read_row(6'd1, '0, 1'b1, "R5");
    idle();
    check(!denied_o, "R5", 64'(denied_o), 64'd0);
    read_sig(64'h1111_2222_3333_4444, "R7");
    issue(3'd2, '0, '0, 64'h0BAD_F00D_CAFE_0001);
    check(!denied_o, "R7", 64'(denied_o), 64'd0);
    read_sig(64'h0BAD_F00D_CAFE_0001, "R7");
    issue(3'd1, 6'd2, 40'h55_5555_5555, '0);
    check(denied_o && done_o, "R6", 64'(denied_o), 64'd1);
    issue(3'd3, '0, '0, '0);
    issue(3'd7, '0, '0, '0);
    check(done_o && !denied_o, "R11", 64'(denied_o), 64'd0);
    issue(3'd0, '0, '0, '0);
    read_row(6'd0, '0, 1'b1, "R8");
  endtask

  task automatic t_wipe();
    issue(3'd4, '0, '0, '0);
    check(done_o && !denied_o, "R9", 64'(denied_o), 64'd0);
    read_row(6'd0, '0, 1'b0, "R9");
    read_row(6'd1, '0, 1'b0, "R9");
    read_row(6'd2, '0, 1'b0, "R6");
    read_row(TOP, '0, 1'b0, "R9");
    read_sig('0, "R9");
    issue(3'd1, 6'd2, 40'h3C_3C3C_3C3C, '0);
    check(!denied_o, "R9", 64'(denied_o), 64'd0);
    read_row(6'd2, 40'h3C_3C3C_3C3C, 1'b0, "R9");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; cmd_valid = 1'b0; cmd_op = '0; cmd_addr = '0; cmd_row = '0; cmd_sig = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_write_read();
    t_unwritten();
    t_sig();
    t_hold();
    t_locked();
    t_wipe();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule